// File: doc/BRIEF.md
# Strobe-Addressed Control and Status Register

This block is a 16-bit control and status register for a system board. Software changes a writable bit by writing to an address decoded for that bit alone. One offset sets the bit and another clears it, and no write data is involved. A read strobe at offset zero returns the whole halfword in one access.

The same halfword also holds status from hardware:

- sticky latches for a bus timeout, a memory parity error, an alignment trap and the periodic timer interrupt;
- a filtered DMA end-of-process latch;
- live copies of the UART interrupt, the floppy interrupt and the I/O board failure line.

Control bits drive dedicated outputs: reset request, diagnostic LED, floppy motor, timer inhibit, fault inhibit and two software interrupt requests.

An address offset is the byte offset inside the register block. Offsets are word aligned, so bits [1:0] are zero, and they run from 0x00 to 0x3C. No other offset decodes.

Top module: `csr_strobe_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, every latched and control bit returns to zero. After reset, a base read shows only the three live status inputs and every control output is low.
- R2: When `bus_rd` is high and `bus_addr` is 0x00, `bus_rdata` returns the full register in the same cycle. The layout is: bit 15 timeout, 14 parity, 13 reset request, 12 alignment trap, 11 LED, 10 motor, 9 zero, 8 timer inhibit, 7 fault inhibit, 6 timer interrupt, 5 software request 8, 4 software request 9, 3 UART, 2 floppy, 1 DMA, 0 board fail. In any other cycle `bus_rdata` is zero.
- R3: A high `evt_bus_timeout` at a clock edge sets bit 15 and the bit stays set. A write to offset 0x00 clears it.
- R4: A high `evt_parity_err` sets bit 14 and the bit stays set. A write to offset 0x04 clears it.
- R5: A high `evt_align_trap` sets bit 12 and a write to 0x0C clears it. A write to 0x08 sets bit 13, which drives `rst_req`. Bit 13 is cleared only by reset.
- R6: Each control bit has a set offset and a clear offset, and its output follows the bit:
  - bit 11, `diag_led`: set 0x10, clear 0x14;
  - bit 10, `fd_motor`: set 0x18, clear 0x1C;
  - bit 8, `tmr_inhibit`: set 0x20, clear 0x24;
  - bit 7, `flt_inhibit`: set 0x28, clear 0x2C;
  - bit 4, `swi9_req`: set 0x30, clear 0x34;
  - bit 5, `swi8_req`: set 0x38, clear 0x3C.
- R7: A high `tmr_tick` sets bit 6. A high `tmr_tick_clr` clears it. No bus offset changes bit 6.
- R8: Bit 1 sets only when `dma_eop` and `dma_uart_xfer` are both high. A `dma_eop` without `dma_uart_xfer` leaves it unchanged. A base read clears it at the end of the read cycle, and that read still shows the old value.
- R9: Bits 3, 2 and 0 follow `uart_irq`, `floppy_irq` and `board_fail` in the same cycle. Bit 9 always reads zero.
- R10: When a hardware set event and a clear of the same latch happen in the same cycle, the bit ends up set.
- R11: A write to an offset that is not word aligned, or that is 0x40 or above, changes no bit and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset inside the register block |
| bus_wr | input | 1 | Write strobe; the offset alone selects the action |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Register contents on a base read, else zero |
| evt_bus_timeout | input | 1 | Bus timeout event (sets bit 15) |
| evt_parity_err | input | 1 | Memory parity error event (sets bit 14) |
| evt_align_trap | input | 1 | Alignment trap event (sets bit 12) |
| tmr_tick | input | 1 | Periodic timer interrupt event (sets bit 6) |
| tmr_tick_clr | input | 1 | Clear strobe for bit 6 |
| dma_eop | input | 1 | DMA end-of-process |
| dma_uart_xfer | input | 1 | High while the DMA transfer serves the UART |
| uart_irq | input | 1 | Live UART interrupt |
| floppy_irq | input | 1 | Live floppy interrupt |
| board_fail | input | 1 | Live I/O board failure |
| rst_req | output | 1 | System reset request (bit 13) |
| diag_led | output | 1 | Diagnostic indicator (bit 11) |
| fd_motor | output | 1 | Floppy motor enable (bit 10) |
| tmr_inhibit | output | 1 | Timer inhibit (bit 8) |
| flt_inhibit | output | 1 | Fault inhibit (bit 7) |
| swi8_req | output | 1 | Software interrupt request 8 (bit 5) |
| swi9_req | output | 1 | Software interrupt request 9 (bit 4) |

## Verification
A decoder that selects the wrong bit for an offset shows up one cycle after the write: a control output moves, or the next base read shows the wrong bit. A latch that loses an event, or gives priority to a clear, shows up on the first read after that cycle. A DMA latch that takes an unqualified end-of-process is visible on the next read. Because the bench reads the register often and compares every output on every clock, such faults appear within a few cycles of the stimulus that exposes them.

// File: rtl/csr_strobe_pkg.sv
// Package: bit positions and latch layout shared by the strobe-addressed CSR.
// Assumes a 16-bit register; positions are fixed because software decodes them.
package csr_strobe_pkg;

    localparam int CSR_W = 16;

    localparam int B_TIMEO  = 15;
    localparam int B_PARITY = 14;
    localparam int B_RSTREQ = 13;
    localparam int B_ALIGN  = 12;
    localparam int B_LED    = 11;
    localparam int B_MOTOR  = 10;
    localparam int B_TINH   = 8;
    localparam int B_FINH   = 7;
    localparam int B_TICK   = 6;
    localparam int B_SWI8   = 5;
    localparam int B_SWI9   = 4;
    localparam int B_UART   = 3;
    localparam int B_FLOP   = 2;
    localparam int B_DMA    = 1;
    localparam int B_BFAIL  = 0;

    // Positions that hold a flop; all others are live inputs or constant zero.
    localparam logic [CSR_W-1:0] LATCH_MASK = 16'b1111_1101_1111_0010;

    typedef struct packed {
        logic [CSR_W-1:0] set;
        logic [CSR_W-1:0] clr;
    } strobe_t;

endpackage

// File: rtl/csr_addr_decode.sv
// Module: csr_addr_decode
// Turns a write strobe and byte offset into one-hot per-bit set/clear strobes.
// Assumes word-aligned offsets 0x00..0x3C; anything else produces no strobe.
module csr_addr_decode
    import csr_strobe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output strobe_t           stb
);

    localparam int SLOT_LSB = 2;
    localparam int SLOT_W   = 4;

    logic              in_block;
    logic [SLOT_W-1:0] slot;

    assign in_block = ((addr >> (SLOT_LSB + SLOT_W)) == '0) && (addr[SLOT_LSB-1:0] == '0);
    assign slot     = addr[SLOT_LSB +: SLOT_W];

    // Purpose: map each word slot to the single bit action it performs.
    always_comb begin
        stb = '0;
        if (wr_en && in_block) begin
            case (slot)
                4'd0:  stb.clr[B_TIMEO]  = 1'b1;
                4'd1:  stb.clr[B_PARITY] = 1'b1;
                4'd2:  stb.set[B_RSTREQ] = 1'b1;
                4'd3:  stb.clr[B_ALIGN]  = 1'b1;
                4'd4:  stb.set[B_LED]    = 1'b1;
                4'd5:  stb.clr[B_LED]    = 1'b1;
                4'd6:  stb.set[B_MOTOR]  = 1'b1;
                4'd7:  stb.clr[B_MOTOR]  = 1'b1;
                4'd8:  stb.set[B_TINH]   = 1'b1;
                4'd9:  stb.clr[B_TINH]   = 1'b1;
                4'd10: stb.set[B_FINH]   = 1'b1;
                4'd11: stb.clr[B_FINH]   = 1'b1;
                4'd12: stb.set[B_SWI9]   = 1'b1;
                4'd13: stb.clr[B_SWI9]   = 1'b1;
                4'd14: stb.set[B_SWI8]   = 1'b1;
                4'd15: stb.clr[B_SWI8]   = 1'b1;
                default: stb = '0;
            endcase
        end
    end

endmodule

// File: rtl/csr_latch_bit.sv
// Module: csr_latch_bit
// One register bit with set priority over clear and synchronous active-low reset.
// Assumes set and clear are single-cycle qualified strobes.
module csr_latch_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // Purpose: hold the bit; a set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

endmodule

// File: rtl/csr_strobe_reg.sv
// Module: csr_strobe_reg (top)
// 16-bit control/status register. Writable bits change by decoded offset only.
// Hardware events set sticky latches, and a base read returns the halfword.
// Assumes inputs are synchronous to clk and reset is synchronous, active low.
module csr_strobe_reg
    import csr_strobe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [CSR_W-1:0]  bus_rdata,
    input  logic              evt_bus_timeout,
    input  logic              evt_parity_err,
    input  logic              evt_align_trap,
    input  logic              tmr_tick,
    input  logic              tmr_tick_clr,
    input  logic              dma_eop,
    input  logic              dma_uart_xfer,
    input  logic              uart_irq,
    input  logic              floppy_irq,
    input  logic              board_fail,
    output logic              rst_req,
    output logic              diag_led,
    output logic              fd_motor,
    output logic              tmr_inhibit,
    output logic              flt_inhibit,
    output logic              swi8_req,
    output logic              swi9_req
);

    strobe_t          sw_stb;
    logic [CSR_W-1:0] hw_set;
    logic [CSR_W-1:0] hw_clr;
    logic [CSR_W-1:0] csr_q;
    logic [CSR_W-1:0] live_bits;
    logic             rd_base;

    assign rd_base = bus_rd && (bus_addr == '0);

    csr_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .stb   (sw_stb)
    );

    // Purpose: collect hardware set events into their bit positions.
    always_comb begin
        hw_set           = '0;
        hw_set[B_TIMEO]  = evt_bus_timeout;
        hw_set[B_PARITY] = evt_parity_err;
        hw_set[B_ALIGN]  = evt_align_trap;
        hw_set[B_TICK]   = tmr_tick;
        hw_set[B_DMA]    = dma_eop && dma_uart_xfer;
    end

    // Purpose: collect clears that do not come from the offset decoder.
    always_comb begin
        hw_clr         = '0;
        hw_clr[B_TICK] = tmr_tick_clr;
        hw_clr[B_DMA]  = rd_base;
    end

    // Purpose: one latch per stored bit, constant zero elsewhere.
    for (genvar b = 0; b < CSR_W; b++) begin : g_bit
        if (LATCH_MASK[b]) begin : g_latch
            csr_latch_bit u_bit (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (hw_set[b] | sw_stb.set[b]),
                .clr_i (hw_clr[b] | sw_stb.clr[b]),
                .q_o   (csr_q[b])
            );
        end else begin : g_none
            assign csr_q[b] = 1'b0;
        end
    end

    // Purpose: place the live status inputs at their read positions.
    always_comb begin
        live_bits          = '0;
        live_bits[B_UART]  = uart_irq;
        live_bits[B_FLOP]  = floppy_irq;
        live_bits[B_BFAIL] = board_fail;
    end

    assign bus_rdata   = rd_base ? (csr_q | live_bits) : '0;
    assign rst_req     = csr_q[B_RSTREQ];
    assign diag_led    = csr_q[B_LED];
    assign fd_motor    = csr_q[B_MOTOR];
    assign tmr_inhibit = csr_q[B_TINH];
    assign flt_inhibit = csr_q[B_FINH];
    assign swi8_req    = csr_q[B_SWI8];
    assign swi9_req    = csr_q[B_SWI9];

    // R3
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_bus_timeout |=> csr_q[B_TIMEO]);

    // R10
    parity_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_parity_err && bus_wr && bus_addr == 8'h04) |=> csr_q[B_PARITY]);

    // R6
    led_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h10) |=> diag_led);

    // R5
    rstreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R8
    dma_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_eop && !dma_uart_xfer && !rd_base) |=> csr_q[B_DMA] == $past(csr_q[B_DMA]));

    // R11
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_stb.set, sw_stb.clr}));

endmodule

// File: tb/csr_strobe_reg_tb.sv
// Bench for csr_strobe_reg: a behavioural model updated on every clock and
// compared with all outputs at each falling edge.
module csr_strobe_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        evt_bus_timeout = 0, evt_parity_err = 0, evt_align_trap = 0;
    logic        tmr_tick = 0, tmr_tick_clr = 0, dma_eop = 0, dma_uart_xfer = 0;
    logic        uart_irq = 0, floppy_irq = 0, board_fail = 0;
    logic        rst_req, diag_led, fd_motor, tmr_inhibit, flt_inhibit, swi8_req, swi9_req;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    string cur_req = "R1";
    logic [15:0] m = '0;
    int    set_tbl[16];
    int    clr_tbl[16];

    always #4 clk = ~clk;

    csr_strobe_reg dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .evt_bus_timeout(evt_bus_timeout),
        .evt_parity_err(evt_parity_err), .evt_align_trap(evt_align_trap),
        .tmr_tick(tmr_tick), .tmr_tick_clr(tmr_tick_clr), .dma_eop(dma_eop),
        .dma_uart_xfer(dma_uart_xfer), .uart_irq(uart_irq), .floppy_irq(floppy_irq),
        .board_fail(board_fail), .rst_req(rst_req), .diag_led(diag_led),
        .fd_motor(fd_motor), .tmr_inhibit(tmr_inhibit), .flt_inhibit(flt_inhibit),
        .swi8_req(swi8_req), .swi9_req(swi9_req)
    );

    // Offset slot -> bit it sets or clears (-1: none), from R3..R6.
    initial begin
        for (int k = 0; k < 16; k++) begin
            set_tbl[k] = -1;
            clr_tbl[k] = -1;
        end
        clr_tbl[0] = 15; clr_tbl[1] = 14; set_tbl[2] = 13; clr_tbl[3] = 12;
        set_tbl[4] = 11; clr_tbl[5] = 11; set_tbl[6] = 10; clr_tbl[7] = 10;
        set_tbl[8] = 8;  clr_tbl[9] = 8;  set_tbl[10] = 7; clr_tbl[11] = 7;
        set_tbl[12] = 4; clr_tbl[13] = 4; set_tbl[14] = 5; clr_tbl[15] = 5;
    end

    // Reference model: clears first, then sets, so sets win (R10).
    always @(posedge clk) begin
        logic [15:0] nx;
        int k;
        cyc <= cyc + 1;
        if (!rst_n) begin
            m <= '0;
        end else begin
            nx = m;
            if (bus_wr && bus_addr < 8'd64 && bus_addr[1:0] == 2'b00) begin
                k = int'(bus_addr) / 4;
                if (clr_tbl[k] >= 0) nx[clr_tbl[k]] = 1'b0;
                if (set_tbl[k] >= 0) nx[set_tbl[k]] = 1'b1;
            end
            if (bus_rd && bus_addr == 8'd0) nx[1] = 1'b0;
            if (tmr_tick_clr) nx[6] = 1'b0;
            if (evt_bus_timeout) nx[15] = 1'b1;
            if (evt_parity_err) nx[14] = 1'b1;
            if (evt_align_trap) nx[12] = 1'b1;
            if (tmr_tick) nx[6] = 1'b1;
            if (dma_eop && dma_uart_xfer) nx[1] = 1'b1;
            m <= nx;
        end
    end

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (cyc >= 2) begin
            logic [15:0] exp_rd;
            exp_rd = (bus_rd && bus_addr == 8'd0) ?
                     (m | {12'd0, uart_irq, floppy_irq, 1'b0, board_fail}) : 16'd0;
            chk("rdata", bus_rdata, exp_rd);
            chk("outputs", {9'd0, rst_req, diag_led, fd_motor, tmr_inhibit, flt_inhibit, swi8_req, swi9_req},
                {9'd0, m[13], m[11], m[10], m[8], m[7], m[5], m[4]});
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        if (cyc > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=50000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        bus_wr = 0; bus_rd = 0; bus_addr = '0;
        evt_bus_timeout = 0; evt_parity_err = 0; evt_align_trap = 0;
        tmr_tick = 0; tmr_tick_clr = 0; dma_eop = 0; dma_uart_xfer = 0;
    endtask

    task automatic wr(input logic [7:0] a);
        bus_addr = a; bus_wr = 1; step();
    endtask

    task automatic rd();
        bus_addr = 8'd0; bus_rd = 1; step();
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) step();
        rst_n = 1; step();
        rd();
        // R2: read at a non-base offset returns zero
        cur_req = "R2";
        bus_addr = 8'h04; bus_rd = 1; step();
        // R3: timeout sticky, cleared at 0x00
        cur_req = "R3";
        evt_bus_timeout = 1; step();
        step(); rd(); wr(8'h00); rd();
        // R4: parity, cleared at 0x04
        cur_req = "R4";
        evt_parity_err = 1; step();
        rd(); wr(8'h00); rd(); wr(8'h04); rd();
        // R5: alignment trap and reset request
        cur_req = "R5";
        evt_align_trap = 1; step();
        rd(); wr(8'h0C); rd(); wr(8'h08); rd();
        for (int k = 0; k < 16; k++) wr(8'(k * 4));
        rd();
        // R6: every set/clear pair
        cur_req = "R6";
        for (int k = 4; k < 16; k += 2) begin
            wr(8'(k * 4)); rd(); wr(8'(k * 4 + 4)); rd();
        end
        wr(8'h10); wr(8'h18); wr(8'h20); wr(8'h28); wr(8'h30); wr(8'h38); rd();
        wr(8'h3C); wr(8'h34); rd();
        // R7: periodic timer latch
        cur_req = "R7";
        tmr_tick = 1; step();
        rd(); wr(8'h18); rd();
        tmr_tick_clr = 1; step(); rd();
        // R8: DMA qualification and clear-on-read
        cur_req = "R8";
        dma_eop = 1; step(); rd();
        dma_uart_xfer = 1; step(); rd();
        dma_eop = 1; dma_uart_xfer = 1; step(); rd(); rd();
        // R9: live status inputs and zero bit
        cur_req = "R9";
        uart_irq = 1; rd(); floppy_irq = 1; rd(); board_fail = 1; uart_irq = 0; rd();
        floppy_irq = 0; board_fail = 0; rd();
        // R10: set wins over simultaneous clear
        cur_req = "R10";
        evt_bus_timeout = 1; bus_wr = 1; bus_addr = 8'h00; step(); rd();
        evt_parity_err = 1; bus_wr = 1; bus_addr = 8'h04; step(); rd();
        tmr_tick = 1; tmr_tick_clr = 1; step(); rd();
        dma_eop = 1; dma_uart_xfer = 1; bus_rd = 1; bus_addr = 8'h00; step(); rd(); rd();
        // R11: unaligned and out-of-block writes
        cur_req = "R11";
        wr(8'h11); wr(8'h02); wr(8'h40); wr(8'h50); wr(8'hFC); wr(8'h83); rd();
        wr(8'h00); wr(8'h04); rd();
        // R1: reset again clears everything, including the reset request
        cur_req = "R1";
        rst_n = 0; step(); step(); rst_n = 1; step(); rd();
        step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule